// File: doc/BRIEF.md
# Table-Driven Dual Wiper Setting Controller

This block steps through a fixed, repeating order of four measurements: die temperature, drain voltage, first drain current and second drain current. An external converter raises a one-cycle done pulse with an 8-bit result at the end of each measurement. The upper bits of each result become a table index. That index reads four small on-chip tables, which hold the base setting for each of two wipers and the offset setting for each wiper. The values read from the tables are placed in base and offset registers. The two wiper codes are the saturating sums of base and offset. They change together, and only once per round, after the second drain-current measurement.

A host reaches the block through a single-cycle register write port. A separate strobe marks the end of a host write cycle, which is where a serial bus stop condition would occur. Two mode bits move control from the automatic path to the host. The first lets the host own the wiper base and offset values. The second lets the host own the table indexes while table reads continue.

Top module: `pot_lut_top`

## Requirements
- R1: After reset both wiper codes are 0 and the measurement phase is temperature (0). The configuration register holds 0x3: base/offset auto on (bit 0 = 1), index auto on (bit 1 = 1), and both offset sources set to drain voltage (bits 2 and 3 = 0).
- R2: The phase output steps 0 (temperature), 1 (drain voltage), 2 (first drain current), 3 (second drain current) and back to 0. It advances by one on each done pulse and otherwise holds. In index-auto mode the table index is result[7:3].
- R3: On a temperature done pulse in base/offset-auto mode, base 1 is loaded from table 0 and base 2 from table 1, both at the temperature index.
- R4: Configuration bit 2 selects where the wiper-1 offset index comes from: 0 means drain voltage, 1 means first drain current. Bit 3 selects the wiper-2 source: 0 means drain voltage, 1 means second drain current. Offset 1 is loaded from table 2 and offset 2 from table 3 when the selected measurement ends.
- R5: In base/offset-auto mode both wiper codes update in the same cycle, one clock after the edge that samples the second drain-current done pulse. At no other time do they change in this mode.
- R6: Each wiper code is base plus offset, clamped at 255 without wrap-around.
- R7: The write address map is as follows. Addresses 0x00 to 0x7F select table (addr[6:5]) and entry (addr[4:0]). 0x80 is the configuration register. 0x81 to 0x83 are the temperature, offset-1 and offset-2 indexes. 0x84 to 0x87 are base 1, offset 1, base 2 and offset 2.
- R8: With base/offset auto cleared, measurements load no table values and cause no wiper update. The host may write the four base and offset registers, and both wipers take the new sums one clock after the end-of-write strobe.
- R9: While base/offset auto is set, host writes to the base and offset registers are ignored, and the end-of-write strobe changes no wiper code.
- R10: With index auto cleared, the three index registers are host-writable and measurement results no longer set them. Table reads still happen at the matching measurement ends, using the stored indexes.
- R11: With index auto cleared, a second drain-current end commits the wipers only if a temperature end has occurred since the last end-of-write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convDone | input | 1 | One-cycle pulse that ends the current measurement |
| convResult | input | 8 | Measurement result, valid with convDone |
| wrEn | input | 1 | Host register write strobe |
| wrAddr | input | 8 | Host write address |
| wrData | input | 8 | Host write data |
| wrEnd | input | 1 | One-cycle end-of-host-write-cycle strobe |
| convPhase | output | 2 | Measurement currently expected |
| pot1Code | output | 8 | Wiper 1 setting |
| pot2Code | output | 8 | Wiper 2 setting |

## Verification
Index, base and offset registers load at the edge that samples a done pulse, and the phase advances at that same edge. The wiper codes move one edge later, because they are fed by a registered commit strobe. The same one-edge delay applies after the end-of-write strobe. The bench drives inputs on falling edges and samples on the falling edge after each expected update. Its directed checks read the old codes at the falling edge just after the final measurement pulse and the new codes one cycle later, so a wiper that updates a cycle early or late fails a check. A behavioural model, stepped on every rising edge, is compared with the phase and both codes on every falling edge.

// File: rtl/pot_lut_pkg.sv
package pot_lut_pkg;

  typedef enum logic [1:0] {
    PH_TEMP = 2'd0,
    PH_VD   = 2'd1,
    PH_ID1  = 2'd2,
    PH_ID2  = 2'd3
  } convPhase_e;

  // register offsets inside the upper half of the address space
  localparam logic [2:0] REG_CFG   = 3'd0;
  localparam logic [2:0] REG_TIDX  = 3'd1;
  localparam logic [2:0] REG_BASE1 = 3'd4;

  typedef struct packed {
    logic       ldTIdx;
    logic       ldO1Idx;
    logic       ldO2Idx;
    logic       rcBase;
    logic       rcOff1;
    logic       rcOff2;
    logic       commit;
    logic       idxAuto;
    logic [2:0] wrIdx;   // temp, off1, off2 index
    logic [3:0] wrBo;    // base1, off1, base2, off2
    logic       wrTab;
  } dpStrobe_t;

endpackage

// File: rtl/pot_lut_ctrl.sv
module pot_lut_ctrl
  import pot_lut_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       convDone,
  input  logic       wrEn,
  input  logic       regSpace,
  input  logic [2:0] regIdx,
  input  logic [3:0] cfgData,
  input  logic       wrEnd,
  output convPhase_e phase,
  output dpStrobe_t  stb,
  output logic       boAuto
);

  logic idxAuto, sel1, sel2;
  logic seenTemp, commitPend;
  logic doneT, doneV, doneI1, doneI2;
  logic off1Done, off2Done;
  logic regWr;

  always_comb begin
    doneT    = convDone && (phase == PH_TEMP);
    doneV    = convDone && (phase == PH_VD);
    doneI1   = convDone && (phase == PH_ID1);
    doneI2   = convDone && (phase == PH_ID2);
    off1Done = (doneV && !sel1) || (doneI1 && sel1);
    off2Done = (doneV && !sel2) || (doneI2 && sel2);
    regWr    = wrEn && regSpace;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_TEMP;
    end else if (convDone) begin
      phase <= convPhase_e'(phase + 2'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      boAuto  <= 1'b1;
      idxAuto <= 1'b1;
      sel1    <= 1'b0;
      sel2    <= 1'b0;
    end else if (regWr && (regIdx == REG_CFG)) begin
      {sel2, sel1, idxAuto, boAuto} <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenTemp   <= 1'b0;
      commitPend <= 1'b0;
    end else begin
      if (wrEnd && !idxAuto) begin
        seenTemp <= 1'b0;
      end else if (doneT) begin
        seenTemp <= 1'b1;
      end
      commitPend <= (doneI2 && boAuto && seenTemp) || (wrEnd && !boAuto);
    end
  end

  always_comb begin
    stb         = '0;
    stb.ldTIdx  = doneT && idxAuto;
    stb.ldO1Idx = off1Done && idxAuto;
    stb.ldO2Idx = off2Done && idxAuto;
    stb.rcBase  = doneT && boAuto;
    stb.rcOff1  = off1Done && boAuto;
    stb.rcOff2  = off2Done && boAuto;
    stb.commit  = commitPend;
    stb.idxAuto = idxAuto;
    stb.wrTab   = wrEn && !regSpace;
    for (int k = 0; k < 3; k++) begin
      stb.wrIdx[k] = regWr && !idxAuto && (regIdx == 3'(REG_TIDX + k));
    end
    for (int k = 0; k < 4; k++) begin
      stb.wrBo[k] = regWr && !boAuto && (regIdx == 3'(REG_BASE1 + k));
    end
  end

endmodule

// File: rtl/pot_lut_dp.sv
module pot_lut_dp
  import pot_lut_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int POT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [IDX_W-1:0] freshIdx,
  input  logic [IDX_W+1:0] tabAddr,
  input  logic [POT_W-1:0] wrData,
  output logic [POT_W-1:0] pot1Code,
  output logic [POT_W-1:0] pot2Code
);

  localparam int TAB_N   = 1 << IDX_W;
  localparam int N_TABS  = 4;

  logic [IDX_W-1:0] tIdxQ, o1IdxQ, o2IdxQ;
  logic [IDX_W-1:0] tSel, o1Sel, o2Sel;
  logic [IDX_W-1:0] rdIdx [N_TABS];
  logic [POT_W-1:0] rdVal [N_TABS];
  logic [POT_W-1:0] base1, off1, base2, off2;

  function automatic logic [POT_W-1:0] satAdd(input logic [POT_W-1:0] a,
                                                input logic [POT_W-1:0] b);
    logic [POT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[POT_W] ? {POT_W{1'b1}} : s[POT_W-1:0];
  endfunction

  always_comb begin
    tSel     = stb.idxAuto ? freshIdx : tIdxQ;
    o1Sel    = stb.idxAuto ? freshIdx : o1IdxQ;
    o2Sel    = stb.idxAuto ? freshIdx : o2IdxQ;
    rdIdx[0] = tSel;
    rdIdx[1] = tSel;
    rdIdx[2] = o1Sel;
    rdIdx[3] = o2Sel;
  end

  for (genvar t = 0; t < N_TABS; t++) begin : g_tab
    logic [POT_W-1:0] mem [TAB_N];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int e = 0; e < TAB_N; e++) mem[e] <= '0;
      end else if (stb.wrTab && (tabAddr[IDX_W+1:IDX_W] == 2'(t))) begin
        mem[tabAddr[IDX_W-1:0]] <= wrData;
      end
    end
    assign rdVal[t] = mem[rdIdx[t]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tIdxQ  <= '0;
      o1IdxQ <= '0;
      o2IdxQ <= '0;
    end else begin
      if (stb.ldTIdx)        tIdxQ  <= freshIdx;
      else if (stb.wrIdx[0]) tIdxQ  <= wrData[IDX_W-1:0];
      if (stb.ldO1Idx)       o1IdxQ <= freshIdx;
      else if (stb.wrIdx[1]) o1IdxQ <= wrData[IDX_W-1:0];
      if (stb.ldO2Idx)       o2IdxQ <= freshIdx;
      else if (stb.wrIdx[2]) o2IdxQ <= wrData[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      base1 <= '0;
      off1  <= '0;
      base2 <= '0;
      off2  <= '0;
    end else begin
      if (stb.rcBase) begin
        base1 <= rdVal[0];
        base2 <= rdVal[1];
      end else begin
        if (stb.wrBo[0]) base1 <= wrData;
        if (stb.wrBo[2]) base2 <= wrData;
      end
      if (stb.rcOff1)       off1 <= rdVal[2];
      else if (stb.wrBo[1]) off1 <= wrData;
      if (stb.rcOff2)       off2 <= rdVal[3];
      else if (stb.wrBo[3]) off2 <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pot1Code <= '0;
      pot2Code <= '0;
    end else if (stb.commit) begin
      pot1Code <= satAdd(base1, off1);
      pot2Code <= satAdd(base2, off2);
    end
  end

endmodule

// File: rtl/pot_lut_top.sv
module pot_lut_top
  import pot_lut_pkg::*;
#(
  parameter int MEAS_W = 8,
  parameter int IDX_W  = 5,
  parameter int POT_W  = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   convDone,
  input  logic [MEAS_W-1:0]      convResult,
  input  logic                   wrEn,
  input  logic [IDX_W+2:0]       wrAddr,
  input  logic [POT_W-1:0]       wrData,
  input  logic                   wrEnd,
  output logic [1:0]             convPhase,
  output logic [POT_W-1:0]       pot1Code,
  output logic [POT_W-1:0]       pot2Code
);

  localparam int ADDR_W = IDX_W + 3;

  convPhase_e phase;
  dpStrobe_t  stb;
  logic       boAuto;

  assign convPhase = phase;

  pot_lut_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .convDone (convDone),
    .wrEn     (wrEn),
    .regSpace (wrAddr[ADDR_W-1]),
    .regIdx   (wrAddr[2:0]),
    .cfgData  (wrData[3:0]),
    .wrEnd    (wrEnd),
    .phase    (phase),
    .stb      (stb),
    .boAuto   (boAuto)
  );

  pot_lut_dp #(
    .IDX_W (IDX_W),
    .POT_W (POT_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .freshIdx (convResult[MEAS_W-1 -: IDX_W]),
    .tabAddr  (wrAddr[IDX_W+1:0]),
    .wrData   (wrData),
    .pot1Code (pot1Code),
    .pot2Code (pot2Code)
  );

endmodule

// File: rtl/pot_lut_chk.sv
module pot_lut_chk
  import pot_lut_pkg::*;
#(
  parameter int POT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             convDone,
  input logic             wrEnd,
  input logic [1:0]       convPhase,
  input logic [POT_W-1:0] pot1Code,
  input logic [POT_W-1:0] pot2Code,
  input dpStrobe_t        stb,
  input logic             boAuto
);

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> (convPhase == 2'($past(convPhase) + 2'd1)));

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !convDone |=> $stable(convPhase));

  // R5
  commit_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> $past((convDone && (convPhase == 2'd3)) || wrEnd));

  // R5
  pot_commit_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(pot1Code) || !$stable(pot2Code)) |-> $past(stb.commit));

  // R8
  manual_bo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!boAuto && !wrEnd) |=> !stb.commit);

endmodule

bind pot_lut_top pot_lut_chk #(.POT_W(POT_W)) uChk (.*);

// File: tb/tb_pot_lut_top.sv
`timescale 1ns/1ps
module tb_pot_lut_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       convDone = 1'b0;
  logic [7:0] convResult = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       wrEnd = 1'b0;
  logic [1:0] convPhase;
  logic [7:0] pot1Code, pot2Code;

  int checks = 0;
  int errors = 0;
  bit running = 0;

  always #2.5 clk = ~clk;

  pot_lut_top dut (
    .clk(clk), .rstN(rstN), .convDone(convDone), .convResult(convResult),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrEnd(wrEnd),
    .convPhase(convPhase), .pot1Code(pot1Code), .pot2Code(pot2Code)
  );

  // ---------- table contents chosen by the bench ----------
  function automatic int fB1(int i); return (i * 7) & 255; endfunction
  function automatic int fB2(int i); return 255 - i * 5; endfunction
  function automatic int fO1(int i); return i * 4; endfunction
  function automatic int fO2(int i); return i * 2 + 10; endfunction
  function automatic int sat(int a, int b); return (a + b > 255) ? 255 : a + b; endfunction

  // ---------- behavioural reference ----------
  int mTab [128];
  int mPh, mTi, mO1, mO2, mB1, mB2, mF1, mF2, mP1, mP2;
  bit mBo, mIx, mS1, mS2, mSeen, mPend;
  int d, ph0, o;
  bit np;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mTab[i]) mTab[i] = 0;
      mPh = 0; mTi = 0; mO1 = 0; mO2 = 0;
      mB1 = 0; mB2 = 0; mF1 = 0; mF2 = 0; mP1 = 0; mP2 = 0;
      mBo = 1; mIx = 1; mS1 = 0; mS2 = 0; mSeen = 0; mPend = 0;
    end else begin
      if (mPend) begin
        mP1 = sat(mB1, mF1);
        mP2 = sat(mB2, mF2);
      end
      np  = (convDone && mPh == 3 && mBo && mSeen) || (wrEnd && !mBo);
      ph0 = mPh;
      d   = int'(convResult) / 8;
      if (convDone) begin
        if (ph0 == 0) begin
          o = mIx ? d : mTi;
          if (mIx) mTi = o;
          if (mBo) begin mB1 = mTab[o]; mB2 = mTab[32 + o]; end
        end
        if ((ph0 == 1 && !mS1) || (ph0 == 2 && mS1)) begin
          o = mIx ? d : mO1;
          if (mIx) mO1 = o;
          if (mBo) mF1 = mTab[64 + o];
        end
        if ((ph0 == 1 && !mS2) || (ph0 == 3 && mS2)) begin
          o = mIx ? d : mO2;
          if (mIx) mO2 = o;
          if (mBo) mF2 = mTab[96 + o];
        end
        mPh = (mPh + 1) % 4;
      end
      if (wrEnd && !mIx) mSeen = 0;
      else if (convDone && ph0 == 0) mSeen = 1;
      if (wrEn) begin
        if (wrAddr < 128) mTab[wrAddr] = int'(wrData);
        else begin
          case (int'(wrAddr) - 128)
            0: begin mBo = wrData[0]; mIx = wrData[1]; mS1 = wrData[2]; mS2 = wrData[3]; end
            1: if (!mIx) mTi = int'(wrData) % 32;
            2: if (!mIx) mO1 = int'(wrData) % 32;
            3: if (!mIx) mO2 = int'(wrData) % 32;
            4: if (!mBo) mB1 = int'(wrData);
            5: if (!mBo) mF1 = int'(wrData);
            6: if (!mBo) mB2 = int'(wrData);
            7: if (!mBo) mF2 = int'(wrData);
            default: ;
          endcase
        end
      end
      mPend = np;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running && rstN) begin
      check("R2", "model phase", int'(convPhase), mPh);
      check("R5", "model pot1", int'(pot1Code), mP1);
      check("R6", "model pot2", int'(pot2Code), mP2);
    end
  end

  // ---------- stimulus helpers ----------
  task automatic hostWr(int a, int v);
    wrAddr = 8'(a); wrData = 8'(v); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic endWr();
    wrEnd = 1'b1;
    @(negedge clk);
    wrEnd = 1'b0;
  endtask

  task automatic conv(int r);
    convResult = 8'(r); convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
  endtask

  // one full round; checks hold before the last pulse and the new codes one cycle after
  task automatic round(string req, int t, int v, int i1, int i2, int e1, int e2);
    int p1, p2;
    conv(t); conv(v); conv(i1);
    p1 = int'(pot1Code); p2 = int'(pot2Code);
    conv(i2);
    check("R5", "pot1 held until commit", int'(pot1Code), p1);
    check("R5", "pot2 held until commit", int'(pot2Code), p2);
    @(negedge clk);
    check(req, "pot1 after round", int'(pot1Code), e1);
    check(req, "pot2 after round", int'(pot2Code), e2);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    running = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "pot1 reset", int'(pot1Code), 0);
    check("R1", "pot2 reset", int'(pot2Code), 0);
    check("R1", "phase reset", int'(convPhase), 0);

    // R7 table fill
    for (int i = 0; i < 32; i++) begin
      hostWr(i, fB1(i));
      hostWr(32 + i, fB2(i));
      hostWr(64 + i, fO1(i));
      hostWr(96 + i, fO2(i));
    end

    // R3 drain-voltage source for both offsets (default selects)
    round("R3", 8'h40, 8'h88, 8'h10, 8'h20, sat(fB1(8), fO1(17)), sat(fB2(8), fO2(17)));
    round("R3", 8'h90, 8'h18, 8'hF0, 8'hE0, sat(fB1(18), fO1(3)), sat(fB2(18), fO2(3)));
    // R4 both offsets from the drain-current results
    hostWr(8'h80, 4'hF);
    round("R4", 8'hF8, 8'h00, 8'h50, 8'hA0, 255, sat(fB2(31), fO2(20)));
    // R6 saturation
    round("R6", 8'h00, 8'h33, 8'hFF, 8'h08, 124, 255);
    // R4 mixed selects: wiper 1 from first current, wiper 2 from voltage
    hostWr(8'h80, 4'h7);
    round("R4", 8'h28, 8'h30, 8'h48, 8'hE0, sat(fB1(5), fO1(9)), sat(fB2(5), fO2(6)));

    // R9 writes ignored in auto mode, end strobe has no effect
    hostWr(8'h84, 8'h11);
    hostWr(8'h81, 7);
    endWr();
    @(negedge clk); @(negedge clk);
    check("R9", "pot1 unchanged after auto write", int'(pot1Code), 71);
    check("R9", "pot2 unchanged after auto write", int'(pot2Code), 252);
    hostWr(8'h80, 4'h6);
    hostWr(8'h85, 0);
    hostWr(8'h87, 0);
    endWr();
    @(negedge clk);
    check("R9", "pot1 base kept from table", int'(pot1Code), fB1(5));
    check("R9", "pot2 base kept from table", int'(pot2Code), fB2(5));

    // R8 manual base/offset
    hostWr(8'h84, 100); hostWr(8'h85, 50); hostWr(8'h86, 200); hostWr(8'h87, 100);
    check("R8", "pot1 waits for end strobe", int'(pot1Code), fB1(5));
    endWr();
    @(negedge clk);
    check("R8", "pot1 manual", int'(pot1Code), 150);
    check("R8", "pot2 manual", int'(pot2Code), 255);
    conv(8'h10); conv(8'h20); conv(8'h30); conv(8'h40);
    @(negedge clk);
    check("R8", "pot1 ignores rounds", int'(pot1Code), 150);
    check("R8", "pot2 ignores rounds", int'(pot2Code), 255);

    // R10 / R11 manual indexes
    hostWr(8'h80, 4'hD);
    conv(8'hFF); conv(8'hFF);
    hostWr(8'h81, 10); hostWr(8'h82, 2); hostWr(8'h83, 1);
    endWr();
    conv(8'hFF); conv(8'hFF);
    @(negedge clk);
    check("R11", "no commit without fresh temperature", int'(pot1Code), 150);
    check("R11", "no commit without fresh temperature", int'(pot2Code), 255);
    round("R10", 8'h00, 8'h00, 8'h00, 8'h00, sat(fB1(10), fO1(2)), sat(fB2(10), fO2(1)));

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule